// File: doc/BRIEF.md
# SCSI Controller Interrupt Cause Register

This block collects the reasons a SCSI protocol controller wants the host's attention. The controller's sequencer reports bus events as one-cycle pulses. The block qualifies each pulse against the controller's current role (target or initiator), folds it into one of eight cause bits, and holds that bit until the host reads the register. While any cause bit is set, a level interrupt goes to the host.

The host reads the byte through a simple read strobe and address. The register answers at byte address 05h. That read returns the cause byte on the cycle after the strobe and empties the register. On the same cycle, the block sends one-cycle clear pulses to two companion status registers, so one read clears all three. An event that lands in the same cycle as the read is kept for the next read.

Top module: `scsi_isr`

## Requirements
- R1: After reset, all eight cause bits are 0, irq is 0, rd_data is 0 and both clear pulses are 0.
- R2: A strobe with rd_en=1 and rd_addr=05h puts the cause byte onto rd_data on the next cycle and empties the register. Bit 7 of the byte is bus reset, then bit 6 bad command, bit 5 disconnect, bit 4 service request, bit 3 operation done, bit 2 reselected, bit 1 selected with ATN and bit 0 selected without ATN. A strobe to any other address leaves the causes untouched. rd_data is 0 on any cycle that does not follow a read of 05h.
- R3: clr_status and clr_internal are both high for exactly the one cycle after a read of 05h, and low otherwise.
- R4: Bit 7 is set by ev_bus_reset only while rst_report_en=1.
- R5: Bit 6 is set on cmd_strobe when cmd_class is 2'b11 (unknown opcode), when it is 2'b01 (target-only) in initiator role, or when it is 2'b10 (initiator-only) in target role. Class 2'b00 is valid in either role.
- R6: Bit 5 is set by ev_seq_disc in target role (role_initiator=0). It is set by ev_tgt_disc or ev_sel_timeout in initiator role (role_initiator=1).
- R7: Bit 4 is set by ev_atn in target role and by ev_phase_req in initiator role.
- R8: Bit 3 is set by ev_cmd_done in either role. In initiator role it is also set by ev_sel_ok or ev_msgin_req.
- R9: Bit 2 is set by ev_resel in either role.
- R10: ev_selected sets bit 1 when sel_atn=1 and bit 0 when sel_atn=0.
- R11: irq is high on every cycle on which any cause bit is set. After a read of 05h with no concurrent event, irq is low on the next cycle.
- R12: A qualified event arriving in the same cycle as a read of 05h remains set after the read and is returned by the following read.
- R13: A set bit stays set until a read of 05h, whatever the role changes and other events in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_initiator | input | 1 | Current role: 1 initiator, 0 target |
| rst_report_en | input | 1 | Enables reporting of bus reset |
| ev_bus_reset | input | 1 | Bus reset detected |
| cmd_strobe | input | 1 | A command was issued |
| cmd_class | input | 2 | Class of the issued command |
| ev_seq_disc | input | 1 | Own terminate/complete sequence left the bus |
| ev_tgt_disc | input | 1 | Target dropped the bus |
| ev_sel_timeout | input | 1 | Selection or reselection timed out |
| ev_atn | input | 1 | Initiator raised ATN |
| ev_phase_req | input | 1 | Target requested an information phase |
| ev_cmd_done | input | 1 | Command completed |
| ev_sel_ok | input | 1 | Selection of a target succeeded |
| ev_msgin_req | input | 1 | Message-in requested after a transfer command |
| ev_resel | input | 1 | Reselection phase ended |
| ev_selected | input | 1 | Selection phase ended with this device selected |
| sel_atn | input | 1 | ATN level during that selection |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 8 | Cause byte returned by the read |
| irq | output | 1 | Interrupt request |
| clr_status | output | 1 | Clear pulse to the companion status register |
| clr_internal | output | 1 | Clear pulse to the internal status register |

## Verification
Each event input is pulsed alone, under both roles, both reset-report settings, both ATN levels and all four command classes. This separates a cause that fires in the wrong role from one that fails to fire in the right role. Pairs of events are then driven together, which exposes cross-wiring between bits that a single event cannot show. A read that coincides with an event shows whether the late event is kept. Role changes between an event and its read show whether bits are sticky. A strobe to a neighbouring address shows that the decode is exact.

// File: rtl/scsi_isr_pkg.sv
package scsi_isr_pkg;

   localparam int unsigned ISR_W = 8;

   typedef enum logic [1:0] {
      CMD_ANY = 2'b00,
      CMD_TGT = 2'b01,
      CMD_INI = 2'b10,
      CMD_BAD = 2'b11
   } cmd_class_e;

   // Packed MSB-first so that field order equals host bit position.
   typedef struct packed {
      logic bus_rst;
      logic bad_cmd;
      logic disc;
      logic svc_req;
      logic op_ok;
      logic resel;
      logic sel_w_atn;
      logic sel_no_atn;
   } isr_bits_t;

endpackage

// File: rtl/scsi_isr_qual.sv
module scsi_isr_qual
   import scsi_isr_pkg::*;
(
   input  logic       role_initiator,
   input  logic       rst_report_en,
   input  logic       ev_bus_reset,
   input  logic       cmd_strobe,
   input  logic [1:0] cmd_class,
   input  logic       ev_seq_disc,
   input  logic       ev_tgt_disc,
   input  logic       ev_sel_timeout,
   input  logic       ev_atn,
   input  logic       ev_phase_req,
   input  logic       ev_cmd_done,
   input  logic       ev_sel_ok,
   input  logic       ev_msgin_req,
   input  logic       ev_resel,
   input  logic       ev_selected,
   input  logic       sel_atn,
   output isr_bits_t  set_vec
);

   cmd_class_e cls;
   logic       in_target;
   logic       wrong_role;

   assign cls        = cmd_class_e'(cmd_class);
   assign in_target  = ~role_initiator;

   always_comb begin
      unique case (cls)
         CMD_ANY: wrong_role = 1'b0;
         CMD_TGT: wrong_role = role_initiator;
         CMD_INI: wrong_role = in_target;
         default: wrong_role = 1'b1;
      endcase
   end

   always_comb begin
      set_vec            = '0;
      set_vec.bus_rst    = ev_bus_reset & rst_report_en;
      set_vec.bad_cmd    = cmd_strobe & wrong_role;
      set_vec.disc       = in_target ? ev_seq_disc
                                     : (ev_tgt_disc | ev_sel_timeout);
      set_vec.svc_req    = in_target ? ev_atn : ev_phase_req;
      set_vec.op_ok      = ev_cmd_done
                         | (role_initiator & (ev_sel_ok | ev_msgin_req));
      set_vec.resel      = ev_resel;
      set_vec.sel_w_atn  = ev_selected & sel_atn;
      set_vec.sel_no_atn = ev_selected & ~sel_atn;
   end

endmodule

// File: rtl/scsi_isr_bits.sv
module scsi_isr_bits #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [WIDTH-1:0] set,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("scsi_isr_bits: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      // New set wins over the clear so a same-cycle event survives.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= set[i] | (q[i] & ~clear);
      end
   end

endmodule

// File: rtl/scsi_isr_host.sv
module scsi_isr_host #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 5,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] status,
   output logic              hit,
   output logic [DATA_W-1:0] rd_data,
   output logic              clr_status,
   output logic              clr_internal
);

   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("scsi_isr_host: ADDR_W out of range");
   end
   if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("scsi_isr_host: REG_ADDR does not fit in ADDR_W");
   end

   assign hit = rd_en & (rd_addr == MATCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data      <= '0;
         clr_status   <= 1'b0;
         clr_internal <= 1'b0;
      end else begin
         rd_data      <= hit ? status : '0;
         clr_status   <= hit;
         clr_internal <= hit;
      end
   end

endmodule

// File: rtl/scsi_isr.sv
module scsi_isr
   import scsi_isr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              role_initiator,
   input  logic              rst_report_en,
   input  logic              ev_bus_reset,
   input  logic              cmd_strobe,
   input  logic [1:0]        cmd_class,
   input  logic              ev_seq_disc,
   input  logic              ev_tgt_disc,
   input  logic              ev_sel_timeout,
   input  logic              ev_atn,
   input  logic              ev_phase_req,
   input  logic              ev_cmd_done,
   input  logic              ev_sel_ok,
   input  logic              ev_msgin_req,
   input  logic              ev_resel,
   input  logic              ev_selected,
   input  logic              sel_atn,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              irq,
   output logic              clr_status,
   output logic              clr_internal
);

   isr_bits_t        set_vec;
   logic [ISR_W-1:0] status_q;
   logic             hit;

   scsi_isr_qual u_qual (
      .role_initiator (role_initiator),
      .rst_report_en  (rst_report_en),
      .ev_bus_reset   (ev_bus_reset),
      .cmd_strobe     (cmd_strobe),
      .cmd_class      (cmd_class),
      .ev_seq_disc    (ev_seq_disc),
      .ev_tgt_disc    (ev_tgt_disc),
      .ev_sel_timeout (ev_sel_timeout),
      .ev_atn         (ev_atn),
      .ev_phase_req   (ev_phase_req),
      .ev_cmd_done    (ev_cmd_done),
      .ev_sel_ok      (ev_sel_ok),
      .ev_msgin_req   (ev_msgin_req),
      .ev_resel       (ev_resel),
      .ev_selected    (ev_selected),
      .sel_atn        (sel_atn),
      .set_vec        (set_vec)
   );

   scsi_isr_bits #(.WIDTH(ISR_W)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (hit),
      .set   (set_vec),
      .q     (status_q)
   );

   scsi_isr_host #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .DATA_W   (ISR_W)
   ) u_host (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .rd_addr      (rd_addr),
      .status       (status_q),
      .hit          (hit),
      .rd_data      (rd_data),
      .clr_status   (clr_status),
      .clr_internal (clr_internal)
   );

   assign irq = |status_q;

endmodule

// File: rtl/scsi_isr_chk.sv
module scsi_isr_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_report_en,
   input logic              ev_any,
   input logic              ev_selected,
   input logic              sel_atn,
   input logic              ev_resel,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        status,
   input logic [7:0]        rd_data,
   input logic              irq,
   input logic              clr_status,
   input logic              clr_internal
);

   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);
   logic rd_hit;
   assign rd_hit = rd_en && (rd_addr == MATCH);

   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (rd_data == $past(status)));
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> (rd_data == 8'h00));
   a_r3_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (clr_status && clr_internal));
   a_r3_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> (!clr_status && !clr_internal));
   a_r4_report_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_report_en && !rd_hit) |=> (status[7] == $past(status[7])));
   a_r10_sel_atn: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_selected && sel_atn) |=> status[1]);
   a_r10_sel_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_selected && !sel_atn) |=> status[0]);
   a_r11_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !ev_any) |=> !irq);
   a_r12_keep_late: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && ev_resel) |=> status[2]);
   a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> ((status & $past(status)) == $past(status)));

endmodule

bind scsi_isr scsi_isr_chk #(
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rst_report_en (rst_report_en),
   .ev_any        (ev_bus_reset | cmd_strobe | ev_seq_disc | ev_tgt_disc |
                   ev_sel_timeout | ev_atn | ev_phase_req | ev_cmd_done |
                   ev_sel_ok | ev_msgin_req | ev_resel | ev_selected),
   .ev_selected   (ev_selected),
   .sel_atn       (sel_atn),
   .ev_resel      (ev_resel),
   .rd_en         (rd_en),
   .rd_addr       (rd_addr),
   .status        (status_q),
   .rd_data       (rd_data),
   .irq           (irq),
   .clr_status    (clr_status),
   .clr_internal  (clr_internal)
);

// File: tb/scsi_isr_tb.sv
module scsi_isr_tb;

   localparam int NEV = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_initiator = 1'b0;
   logic       rst_report_en = 1'b0;
   logic [NEV-1:0] ev = '0;
   logic [1:0] cmd_class = 2'b00;
   logic       sel_atn = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       irq, clr_status, clr_internal;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   scsi_isr u_dut (
      .clk(clk), .rst_n(rst_n),
      .role_initiator(role_initiator), .rst_report_en(rst_report_en),
      .ev_bus_reset(ev[0]), .cmd_strobe(ev[1]), .cmd_class(cmd_class),
      .ev_seq_disc(ev[2]), .ev_tgt_disc(ev[3]), .ev_sel_timeout(ev[4]),
      .ev_atn(ev[5]), .ev_phase_req(ev[6]), .ev_cmd_done(ev[7]),
      .ev_sel_ok(ev[8]), .ev_msgin_req(ev[9]), .ev_resel(ev[10]),
      .ev_selected(ev[11]), .sel_atn(sel_atn),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .clr_status(clr_status), .clr_internal(clr_internal)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_byte(input logic [NEV-1:0] m, input logic ini,
                                              input logic en, input logic atn,
                                              input logic [1:0] cls);
      logic [7:0] b;
      b[7] = m[0] & en;
      b[6] = m[1] & ((cls == 2'b11) || (cls == 2'b01 && ini) || (cls == 2'b10 && !ini));
      b[5] = ini ? (m[3] | m[4]) : m[2];
      b[4] = ini ? m[6] : m[5];
      b[3] = m[7] | (ini & (m[8] | m[9]));
      b[2] = m[10];
      b[1] = m[11] & atn;
      b[0] = m[11] & ~atn;
      return b;
   endfunction

   // Pulse a set of events for one cycle; sampled at the following negedge.
   task automatic pulse(input logic [NEV-1:0] m);
      @(negedge clk);
      ev = m;
      @(negedge clk);
      ev = '0;
   endtask

   // Read 05h, optionally with events in the same cycle; check at next negedge.
   task automatic do_read(input string req, input logic [7:0] exp, input logic [NEV-1:0] late);
      rd_en = 1'b1; rd_addr = 8'h05; ev = late;
      @(negedge clk);
      rd_en = 1'b0; ev = '0;
      chk(req, rd_data, exp);
      chk("R3", {7'd0, clr_status & clr_internal}, 8'd1);
      @(negedge clk);
      chk("R3", {6'd0, clr_status, clr_internal}, 8'd0);
      chk("R2", rd_data, 8'h00);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] e;
      logic [7:0] e2;
      repeat (3) @(negedge clk);
      // R1
      chk("R1", rd_data, 8'h00);
      chk("R1", {5'd0, irq, clr_status, clr_internal}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {7'd0, irq}, 8'h00);

      // Single-event sweep: R4 R5 R6 R7 R8 R9 R10 R11
      for (int mo = 0; mo < 2; mo++)
         for (int en = 0; en < 2; en++)
            for (int at = 0; at < 2; at++)
               for (int cl = 0; cl < 4; cl++)
                  for (int k = 0; k < NEV; k++) begin
                     role_initiator = mo[0]; rst_report_en = en[0];
                     sel_atn = at[0]; cmd_class = cl[1:0];
                     pulse(NEV'(1) << k);
                     e = expect_byte(NEV'(1) << k, mo[0], en[0], at[0], cl[1:0]);
                     chk("R11", {7'd0, irq}, {7'd0, |e});
                     do_read($sformatf("R4-R10 ev%0d", k), e, '0);
                     chk("R11", {7'd0, irq}, 8'h00);
                  end

      // Pair sweep: cross-wiring between bits
      rst_report_en = 1'b1;
      for (int mo = 0; mo < 2; mo++)
         for (int i = 0; i < NEV; i++)
            for (int j = i + 1; j < NEV; j++) begin
               logic [NEV-1:0] m;
               role_initiator = mo[0];
               sel_atn = (i + j) % 2 == 1;
               cmd_class = 2'((i + j) % 4);
               m = (NEV'(1) << i) | (NEV'(1) << j);
               pulse(m);
               e = expect_byte(m, mo[0], 1'b1, sel_atn, cmd_class);
               do_read("R2 pair", e, '0);
            end

      // R12: event in the same cycle as the read survives
      role_initiator = 1'b1; sel_atn = 1'b0;
      pulse(NEV'(1) << 7);
      do_read("R12 first", 8'h08, NEV'(1) << 10);
      chk("R12 irq", {7'd0, irq}, 8'h01);
      do_read("R12 kept", 8'h04, '0);
      // R12 with the same bit both pending and arriving
      pulse(NEV'(1) << 10);
      do_read("R12 same", 8'h04, NEV'(1) << 10);
      do_read("R12 same kept", 8'h04, '0);

      // R13: sticky across role change and unrelated events
      role_initiator = 1'b0; sel_atn = 1'b0;
      pulse(NEV'(1) << 11);
      role_initiator = 1'b1;
      pulse(NEV'(1) << 2);
      role_initiator = 1'b0;
      pulse(NEV'(1) << 6);
      repeat (4) @(negedge clk);
      chk("R13 irq", {7'd0, irq}, 8'h01);
      do_read("R13", 8'h01, '0);

      // R2: neighbouring address neither returns nor clears
      role_initiator = 1'b0;
      pulse(NEV'(1) << 5);
      for (int a = 4; a < 7; a += 2) begin
         rd_en = 1'b1; rd_addr = 8'(a);
         @(negedge clk);
         rd_en = 1'b0;
         chk("R2 miss data", rd_data, 8'h00);
         chk("R3 miss", {6'd0, clr_status, clr_internal}, 8'h00);
         chk("R2 miss irq", {7'd0, irq}, 8'h01);
      end
      do_read("R2 after miss", 8'h10, '0);

      // R4: reset reporting disabled, then enabled, accumulated
      rst_report_en = 1'b0;
      pulse(NEV'(1) << 0);
      rst_report_en = 1'b1;
      pulse(NEV'(1) << 4);
      e2 = 8'h00;
      do_read("R4 off", e2, '0);
      pulse(NEV'(1) << 0);
      do_read("R4 on", 8'h80, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule